// File: doc/BRIEF.md
# Addressed Serial Programming Port for a Frequency Synthesizer

This block receives programming words for a frequency synthesizer over a three-wire serial bus made of a serial clock, a serial data line and a latch line. The bus runs at up to 10 MHz. The three lines arrive asynchronously and are brought into the system clock domain, which must be several times faster than the serial clock. Bits are collected into a 24-bit word while the latch is low. A rising edge on the latch then decodes that word.

Each word carries a device address and a register address. Two synthesizers can therefore sit on one bus, with each one strapped to a different device address through its `dev_id` input. When the device address matches and the register address names a register that exists, the block writes the payload into that register. It also raises a one-cycle update strobe for that register only.

When the configuration register has forced-reload mode set, a write to the reference or main divider also raises a reload pulse in the same cycle. Downstream counters use this pulse to load the new value at once instead of waiting to reach zero.

Top module: `synth_prog_port`

## Requirements
- R1: While and after reset, every register output is zero, `upd` is 3'b000 and `reload` is 0.
- R2: A data bit is taken on each rising serial clock edge while the latch is low, most significant bit first. The word is the last 24 bits taken, so any earlier leading bits are dropped.
- R3: Word layout: bit 23 is the device address, bits 22:20 are the register address, and bits 19:0 are the payload.
- R4: On a latch rising edge with a matching device address, each register takes its fields from the payload as follows. Address 0 loads the reference divider from payload[10:0]. Address 1 loads main A from payload[6:0] and main M from payload[17:7]. Address 2 loads the configuration: polarity from bit 0, powerdown from bit 1, forced-reload mode from bit 2, and charge-pump current from bits 6:3.
- R5: A word whose device address differs from `dev_id` raises no strobe and no reload, and changes no output.
- R6: A matching word with register address 3 to 7 raises no strobe and no reload, and changes no output.
- R7: Each accepted word raises exactly one `upd` bit (bit 0 reference, bit 1 main, bit 2 configuration) for exactly one clock cycle. The register shows its new value in that same cycle.
- R8: `reload` pulses in the same cycle as a reference or main strobe if forced-reload mode was set before the word arrived. It never pulses on a configuration write or while the mode is clear.
- R9: Serial clock rising edges seen while the latch is high are not shifted in. This includes an edge that reaches the block in the same cycle as the latch rising edge.
- R10: Register outputs hold their value between their own writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bus clock (asynchronous) |
| ser_dat | input | 1 | Serial bus data (asynchronous) |
| ser_lat | input | 1 | Serial bus latch, rising edge commits the word |
| dev_id | input | 1 | Device address this instance answers to |
| ref_div | output | 11 | Reference divider value |
| main_a | output | 7 | Main divider A (swallow) count |
| main_m | output | 11 | Main divider M count |
| pd_pol | output | 1 | Detector polarity select |
| pwr_dn | output | 1 | Powerdown request |
| reload_mode | output | 1 | Forced-reload mode enable |
| cp_cur | output | 4 | Charge-pump current setting |
| upd | output | 3 | Per-register one-cycle update strobes |
| reload | output | 1 | Forced counter reload pulse |

## Verification
Two of the block's functions can fall in the same synchronized cycle: shifting a serial bit and committing the word on a latch edge. The bench provokes this by raising the serial clock and the latch in the same instant, after a word whose register address is 0. If that extra bit were shifted in, the word would move into a non-matching device address and no write would happen. The bench therefore judges the result by the reference strobe count and the reference value. Forced reload and the update strobe also share a cycle. The bench counts reload pulses that arrive with no reference or main strobe, and it compares every pulse with a model that tracks the mode bit as it stood before each word.

// File: rtl/sprog_pkg.sv
package sprog_pkg;

    // word geometry
    localparam int WORD_W   = 24;
    localparam int DEV_W    = 1;
    localparam int ADDR_W   = 3;
    localparam int PAY_W    = WORD_W - DEV_W - ADDR_W;

    // register field widths
    localparam int REF_W    = 11;
    localparam int MAIN_A_W = 7;
    localparam int MAIN_M_W = 11;
    localparam int CUR_W    = 4;
    localparam int MAIN_W   = MAIN_A_W + MAIN_M_W;

    // register indices (also the register address values)
    localparam int NUM_REGS = 3;
    localparam int UPD_REF  = 0;
    localparam int UPD_MAIN = 1;
    localparam int UPD_CFG  = 2;

    // serial bus line positions in the synchronizer vector
    localparam int NUM_LINES = 3;
    localparam int LN_CLK    = 0;
    localparam int LN_DAT    = 1;
    localparam int LN_LAT    = 2;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [ADDR_W-1:0] addr;
        logic [PAY_W-1:0]  payload;
    } word_t;

    typedef struct packed {
        logic [MAIN_M_W-1:0] m;
        logic [MAIN_A_W-1:0] a;
    } main_t;

    typedef struct packed {
        logic [CUR_W-1:0] cp_cur;
        logic             force_mode;
        logic             pwr_dn;
        logic             pd_pol;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    // one-hot register select for an address; zero when no such register
    function automatic logic [NUM_REGS-1:0] addr_onehot(input logic [ADDR_W-1:0] a);
        logic [NUM_REGS-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (a == ADDR_W'(i)) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] rise_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // STAGES synchronizer flops plus one history flop for edge detection
        logic [STAGES:0] pipe;

        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-1:0], async_i[g]};
        end

        assign level_o[g] = pipe[STAGES-1];
        assign rise_o[g]  = pipe[STAGES-1] & ~pipe[STAGES];
    end

endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import sprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);

    always_ff @(posedge clk) begin
        if (rst)           word_o <= '0;
        else if (shift_en) word_o <= {word_o[WORD_W-2:0], bit_i};
    end

endmodule

// File: rtl/prog_reg_bank.sv
module prog_reg_bank
    import sprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DEV_W-1:0]  dev_id_i,
    output logic [REF_W-1:0]  ref_o,
    output main_t             main_o,
    output cfg_t              cfg_o,
    output logic [NUM_REGS-1:0] upd_o,
    output logic              reload_o
);

    word_t               w;
    logic [NUM_REGS-1:0] sel;
    logic                unused_payload;

    assign w   = word_t'(word_i);
    assign sel = (load_i && (w.dev == dev_id_i)) ? addr_onehot(w.addr) : '0;
    assign unused_payload = ^w.payload;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_o    <= '0;
            main_o   <= '0;
            cfg_o    <= '0;
            upd_o    <= '0;
            reload_o <= 1'b0;
        end else begin
            upd_o    <= sel;
            // mode as held before this word decides the pulse
            reload_o <= (sel[UPD_REF] | sel[UPD_MAIN]) & cfg_o.force_mode;
            if (sel[UPD_REF])  ref_o  <= w.payload[REF_W-1:0];
            if (sel[UPD_MAIN]) main_o <= main_t'(w.payload[MAIN_W-1:0]);
            if (sel[UPD_CFG])  cfg_o  <= cfg_t'(w.payload[CFG_W-1:0]);
        end
    end

endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import sprog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_lat,
    input  logic [DEV_W-1:0]     dev_id,
    output logic [REF_W-1:0]     ref_div,
    output logic [MAIN_A_W-1:0]  main_a,
    output logic [MAIN_M_W-1:0]  main_m,
    output logic                 pd_pol,
    output logic                 pwr_dn,
    output logic                 reload_mode,
    output logic [CUR_W-1:0]     cp_cur,
    output logic [NUM_REGS-1:0]  upd,
    output logic                 reload
);

    logic [NUM_LINES-1:0] bus_raw;
    logic [NUM_LINES-1:0] bus_lvl;
    logic [NUM_LINES-1:0] bus_rise;
    logic                 shift_en;
    logic [WORD_W-1:0]    sr_word;
    main_t                main_q;
    cfg_t                 cfg_q;

    assign bus_raw[LN_CLK] = ser_clk;
    assign bus_raw[LN_DAT] = ser_dat;
    assign bus_raw[LN_LAT] = ser_lat;

    serial_sync #(
        .LINES  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (bus_raw),
        .level_o (bus_lvl),
        .rise_o  (bus_rise)
    );

    // shifting is frozen whenever the synchronized latch is high
    assign shift_en = bus_rise[LN_CLK] & ~bus_lvl[LN_LAT];

    word_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .bit_i    (bus_lvl[LN_DAT]),
        .word_o   (sr_word)
    );

    prog_reg_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .load_i   (bus_rise[LN_LAT]),
        .word_i   (sr_word),
        .dev_id_i (dev_id),
        .ref_o    (ref_div),
        .main_o   (main_q),
        .cfg_o    (cfg_q),
        .upd_o    (upd),
        .reload_o (reload)
    );

    assign main_a      = main_q.a;
    assign main_m      = main_q.m;
    assign pd_pol      = cfg_q.pd_pol;
    assign pwr_dn      = cfg_q.pwr_dn;
    assign reload_mode = cfg_q.force_mode;
    assign cp_cur      = cfg_q.cp_cur;

endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk
    import sprog_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [REF_W-1:0]    ref_div,
    input logic [MAIN_A_W-1:0] main_a,
    input logic [MAIN_M_W-1:0] main_m,
    input logic                pd_pol,
    input logic                pwr_dn,
    input logic                reload_mode,
    input logic [CUR_W-1:0]    cp_cur,
    input logic [NUM_REGS-1:0] upd,
    input logic                reload
);

    // R7
    upd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd));

    // R7
    upd_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (|upd) |=> (upd == '0));

    // R8
    reload_with_div_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        reload |-> (upd[UPD_REF] | upd[UPD_MAIN]));

    // R8
    reload_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
        reload |-> $past(reload_mode));

    // R10
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd[UPD_REF] |-> $stable(ref_div));

    // R10
    main_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd[UPD_MAIN] |-> ($stable(main_a) && $stable(main_m)));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd[UPD_CFG] |-> ($stable(pd_pol) && $stable(pwr_dn)
                           && $stable(reload_mode) && $stable(cp_cur)));

endmodule

bind synth_prog_port synth_prog_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_div     (ref_div),
    .main_a      (main_a),
    .main_m      (main_m),
    .pd_pol      (pd_pol),
    .pwr_dn      (pwr_dn),
    .reload_mode (reload_mode),
    .cp_cur      (cp_cur),
    .upd         (upd),
    .reload      (reload)
);

// File: tb/test_synth_prog_port.sv
`timescale 1ns/1ps
module test_synth_prog_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_lat = 1'b0;
    logic [0:0]  dev_id = 1'b1;
    logic [10:0] ref_div;
    logic [6:0]  main_a;
    logic [10:0] main_m;
    logic        pd_pol, pwr_dn, reload_mode;
    logic [3:0]  cp_cur;
    logic [2:0]  upd;
    logic        reload;

    always #2 clk = ~clk;

    synth_prog_port i_synth_prog_port (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
        .dev_id(dev_id), .ref_div(ref_div), .main_a(main_a), .main_m(main_m),
        .pd_pol(pd_pol), .pwr_dn(pwr_dn), .reload_mode(reload_mode), .cp_cur(cp_cur),
        .upd(upd), .reload(reload)
    );

    int checks = 0;
    int errors = 0;

    // cumulative monitors, sampled away from the active edge
    int n_upd [3] = '{0, 0, 0};
    int n_rl = 0;
    int n_rl_alone = 0;
    int snap_ref = 0, snap_a = 0, snap_m = 0, snap_cfg = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (upd[0]) begin n_upd[0]++; snap_ref = ref_div; end
            if (upd[1]) begin n_upd[1]++; snap_a = main_a; snap_m = main_m; end
            if (upd[2]) begin n_upd[2]++; snap_cfg = {cp_cur, reload_mode, pwr_dn, pd_pol}; end
            if (reload) begin
                n_rl++;
                if (!(upd[0] || upd[1])) n_rl_alone++;
            end
        end
    end

    // reference model
    int m_ref = 0, m_a = 0, m_m = 0, m_pol = 0, m_pdn = 0, m_frc = 0, m_cur = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = w[i];
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic latch_pulse();
        wait_cyc(4);
        ser_lat = 1'b1;
        wait_cyc(6);
        ser_lat = 1'b0;
        wait_cyc(6);
    endtask

    task automatic check_regs(input string req);
        chk({req, " ref_div"}, int'(ref_div), m_ref);
        chk({req, " main_a"}, int'(main_a), m_a);
        chk({req, " main_m"}, int'(main_m), m_m);
        chk({req, " pd_pol"}, int'(pd_pol), m_pol);
        chk({req, " pwr_dn"}, int'(pwr_dn), m_pdn);
        chk({req, " reload_mode"}, int'(reload_mode), m_frc);
        chk({req, " cp_cur"}, int'(cp_cur), m_cur);
    endtask

    // expected counts for one committed word, applied to the model
    task automatic expect_word(input int dev, input int addr, input int pay,
                               input int u0, input int u1, input int u2, input int rl0,
                               input int ra0, input string req);
        int acc;
        int exp_rl;
        acc = (dev == int'(dev_id)) && (addr < 3);
        exp_rl = acc && (addr < 2) && (m_frc != 0);
        if (acc) begin
            case (addr)
                0: m_ref = pay & 'h7FF;
                1: begin m_a = pay & 'h7F; m_m = (pay >> 7) & 'h7FF; end
                default: begin
                    m_pol = pay & 1; m_pdn = (pay >> 1) & 1;
                    m_frc = (pay >> 2) & 1; m_cur = (pay >> 3) & 'hF;
                end
            endcase
        end
        // R7 one strobe on the addressed register only; R5 and R6 none otherwise
        chk({req, " R7 ref strobes"},  n_upd[0] - u0, (acc && addr == 0) ? 1 : 0);
        chk({req, " R7 main strobes"}, n_upd[1] - u1, (acc && addr == 1) ? 1 : 0);
        chk({req, " R7 cfg strobes"},  n_upd[2] - u2, (acc && addr == 2) ? 1 : 0);
        // R8 reload pulse decided by the mode held before the word
        chk({req, " R8 reload count"}, n_rl - rl0, exp_rl);
        chk({req, " R8 reload without strobe"}, n_rl_alone - ra0, 0);
        // R7 value visible in the strobe cycle
        if (acc && addr == 0) chk({req, " R7 ref at strobe"}, snap_ref, m_ref);
        if (acc && addr == 1) chk({req, " R7 main at strobe"}, snap_a + (snap_m << 7), m_a + (m_m << 7));
        if (acc && addr == 2) chk({req, " R7 cfg at strobe"}, snap_cfg,
                                  m_pol + (m_pdn << 1) + (m_frc << 2) + (m_cur << 3));
        check_regs({req, " R4 R10"});
    endtask

    task automatic do_word(input int dev, input int addr, input int pay, input string req);
        logic [31:0] w;
        int u0, u1, u2, rl0, ra0;
        w = {8'h00, dev[0], addr[2:0], pay[19:0]};   // R3 layout
        u0 = n_upd[0]; u1 = n_upd[1]; u2 = n_upd[2]; rl0 = n_rl; ra0 = n_rl_alone;
        shift_bits(w, 24);
        latch_pulse();
        expect_word(dev, addr, pay, u0, u1, u2, rl0, ra0, req);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        // R1 reset state
        check_regs("R1 in reset");
        chk("R1 upd in reset", int'(upd), 0);
        chk("R1 reload in reset", int'(reload), 0);
        rst = 1'b0;
        wait_cyc(4);
        check_regs("R1 after reset");
        chk("R1 upd after reset", int'(upd), 0);
        chk("R1 reload after reset", int'(reload), 0);

        // R3 R4 R5 R6 R8 sweep: both device addresses, all register addresses
        for (int k = 0; k < 2; k++)
            for (int dv = 0; dv < 2; dv++)
                for (int ad = 0; ad < 8; ad++)
                    do_word(dv, ad, (ad * 'h2F1B + dv * 'h513 + k * 'h9C47 + 'h1A6) & 'hFFFFF,
                            "sweep R3 R5 R6");

        // R5 second strap value
        dev_id = 1'b0;
        for (int dv = 0; dv < 2; dv++)
            for (int ad = 0; ad < 3; ad++)
                do_word(dv, ad, (ad * 'h3A5C + dv * 'hB7 + 'h5E1) & 'hFFFFF, "strap0 R5");
        dev_id = 1'b1;

        // R8 forced mode on then off
        do_word(1, 2, 'h0007C, "R8 mode on");
        do_word(1, 0, 'h00555, "R8 ref forced");
        do_word(1, 1, 'h3ABCD, "R8 main forced");
        do_word(1, 2, 'h00003, "R8 mode off");
        do_word(1, 0, 'h002AA, "R8 ref normal");

        // R2 two leading junk bits are dropped
        begin
            int u0, u1, u2, rl0, ra0;
            u0 = n_upd[0]; u1 = n_upd[1]; u2 = n_upd[2]; rl0 = n_rl; ra0 = n_rl_alone;
            shift_bits({6'h00, 2'b01, 1'b1, 3'd0, 20'h00631}, 26);
            latch_pulse();
            expect_word(1, 0, 'h00631, u0, u1, u2, rl0, ra0, "R2 extra bits");
        end

        // R9 serial edge coinciding with latch edge is not shifted
        begin
            int u0, u1, u2, rl0, ra0;
            u0 = n_upd[0]; u1 = n_upd[1]; u2 = n_upd[2]; rl0 = n_rl; ra0 = n_rl_alone;
            shift_bits({8'h00, 1'b1, 3'd0, 20'h0071E}, 24);
            ser_dat = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b1;
            ser_lat = 1'b1;
            wait_cyc(6);
            ser_clk = 1'b0;
            ser_lat = 1'b0;
            wait_cyc(6);
            expect_word(1, 0, 'h0071E, u0, u1, u2, rl0, ra0, "R9 same-cycle edge");
        end

        // R9 bits clocked while latch is high are ignored
        begin
            int u0, u1, u2, rl0, ra0;
            wait_cyc(4);
            ser_lat = 1'b1;                     // recommits the held word
            wait_cyc(6);
            shift_bits({8'h00, 1'b1, 3'd0, 20'h00123}, 24);
            wait_cyc(4);
            ser_lat = 1'b0;
            wait_cyc(6);
            u0 = n_upd[0]; u1 = n_upd[1]; u2 = n_upd[2]; rl0 = n_rl; ra0 = n_rl_alone;
            latch_pulse();
            expect_word(1, 0, 'h0071E, u0, u1, u2, rl0, ra0, "R9 shifts under latch");
        end

        finish_run();
    end

endmodule